// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block generates data-memory addresses for a DSP datapath. It holds four index pointers, four modify (step) registers and four length registers. On each indirect access the selected pointer is issued, registered, as the memory address. In the same clock edge that pointer is advanced by the step value from an independently selected modify register. The step is a signed 14-bit two's complement number, so a pointer can move forward or backward.

Each pointer has its own length register. With a nonzero length, the pointer stays inside a circular buffer. The base of that buffer is the value last written to the pointer, aligned down to the smallest power of two that is not below the length. A step that leaves the window is brought back by adding or subtracting the length. With a zero length, the pointer advances linearly and wraps modulo 2^14. A per-access flag issues the pointer with its 14 bits mirrored, for FFT-style reordering. The stored pointer is updated as usual in that mode.

Software loads the registers through a single write port. The port carries a kind code, a 2-bit register select and 14 bits of data.

Top module: `circ_agen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `addr_valid` is 0 and `addr_out` is 0. `addr_out` keeps its value in every cycle that follows a cycle without `acc_en`.
- R2: When `acc_en` is high on a clock edge, `addr_valid` is 1 in the following cycle and `addr_out` holds the selected pointer's value from before that edge. The advanced value is seen only by the next access.
- R3: The pointer chosen by `acc_ptr` is advanced by the modify register chosen by `acc_mod`, which may be any of the four. The modify value is a signed 14-bit two's complement step.
- R4: With the pointer's length at 0, the pointer advances linearly modulo 2^14. For example, 16383 plus 1 gives 0, and 0 plus −1 gives 16383.
- R5: With a nonzero length L, the window is [B, B+L−1]. B is the last written pointer value with its low bits cleared, to a multiple of the smallest power of two ≥ L. A forward step that passes B+L−1 subtracts L from the result.
- R6: In circular mode, a backward step that goes below B adds L to the result.
- R7: With `bitrev` high, `addr_out` is the selected pointer with bit i moved to bit 13−i. The pointer is still advanced as in R3–R6.
- R8: A write of kind 0 (index) to the pointer being accessed in the same cycle wins over the post-modify. The pointer then holds the written value.
- R9: Register writes take effect on the clock edge. An access in the same cycle as a write of kind 1 (modify) or kind 2 (length) uses the old values.
- R10: A write of kind 3 changes no register. Accesses to each pointer leave the other three pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 index, 1 modify, 2 length, 3 none |
| wr_sel | input | 2 | Register number within the kind |
| wr_data | input | 14 | Write data |
| acc_en | input | 1 | Indirect access strobe |
| acc_ptr | input | 2 | Pointer to issue and update |
| acc_mod | input | 2 | Modify register applied to that pointer |
| bitrev | input | 1 | Issue the address bit-reversed |
| addr_valid | output | 1 | Registered address valid |
| addr_out | output | 14 | Registered memory address |

## Verification
Two situations are hard to reach from the ports. The first is a circular wrap whose buffer base is not at zero. The second is a write that collides with an access to the same pointer. For the wrap, the stimulus first loads a pointer at an unaligned-looking value inside a larger power-of-two block. It then sets a length that is not a power of two and walks the pointer forward and backward across both ends of the window. For the collision, an index write, a step write and a length write are each driven in the same cycle as an access. The following accesses then reveal which value survived.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;
  typedef enum logic [1:0] {
    RK_INDEX  = 2'd0,
    RK_MODIFY = 2'd1,
    RK_LENGTH = 2'd2,
    RK_NONE   = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/circ_agen_regs.sv
module circ_agen_regs
  import circ_agen_pkg::*;
#(
  parameter int AW = 14,
  parameter int N  = 4,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_sel,
  input  logic [AW-1:0] upd_val,
  input  logic [SW-1:0] rd_ptr,
  input  logic [SW-1:0] rd_mod,
  output logic [AW-1:0] cur_idx,
  output logic [AW-1:0] cur_anchor,
  output logic [AW-1:0] cur_len,
  output logic [AW-1:0] cur_modv
);
  logic [AW-1:0] idx_q [N];
  logic [AW-1:0] anc_q [N];
  logic [AW-1:0] len_q [N];
  logic [AW-1:0] mod_q [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic hit_idx, hit_len, hit_mod;
    assign hit_idx = wr_en && (reg_kind_e'(wr_kind) == RK_INDEX)  && (wr_sel == SW'(i));
    assign hit_mod = wr_en && (reg_kind_e'(wr_kind) == RK_MODIFY) && (wr_sel == SW'(i));
    assign hit_len = wr_en && (reg_kind_e'(wr_kind) == RK_LENGTH) && (wr_sel == SW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        idx_q[i] <= '0;
        anc_q[i] <= '0;
      end else if (hit_idx) begin
        idx_q[i] <= wr_data;
        anc_q[i] <= wr_data;
      end else if (upd_en && (upd_sel == SW'(i))) begin
        idx_q[i] <= upd_val;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mod_q[i] <= '0;
        len_q[i] <= '0;
      end else begin
        if (hit_mod) mod_q[i] <= wr_data;
        if (hit_len) len_q[i] <= wr_data;
      end
    end
  end

  assign cur_idx    = idx_q[rd_ptr];
  assign cur_anchor = anc_q[rd_ptr];
  assign cur_len    = len_q[rd_ptr];
  assign cur_modv   = mod_q[rd_mod];
endmodule

// File: rtl/circ_agen_update.sv
module circ_agen_update #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] anchor,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] modv,
  output logic [AW-1:0] base,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] span_m;
  logic signed [AW+1:0] off, adj, lenx;

  always_comb begin
    span_m = len - AW'(1);
    for (int k = 0; k < AW; k++) span_m = span_m | (span_m >> 1);
  end

  assign base = anchor & ~span_m;
  assign lenx = $signed({2'b00, len});

  always_comb begin
    off = $signed({2'b00, ptr}) - $signed({2'b00, base}) + $signed({{2{modv[AW-1]}}, modv});
    if (off >= lenx)      adj = off - lenx;
    else if (off < 0)     adj = off + lenx;
    else                  adj = off;
  end

  assign nxt = (len == '0) ? (ptr + modv) : (base + adj[AW-1:0]);
endmodule

// File: rtl/circ_agen_bitrev.sv
module circ_agen_bitrev #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] din,
  output logic [AW-1:0] dout
);
  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign dout[i] = din[AW-1-i];
  end
endmodule

// File: rtl/circ_agen.sv
module circ_agen #(
  parameter int AW = 14,
  parameter int N  = 4,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          acc_en,
  input  logic [SW-1:0] acc_ptr,
  input  logic [SW-1:0] acc_mod,
  input  logic          bitrev,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out
);
  logic [AW-1:0] cur_idx, cur_anchor, cur_len, cur_modv;
  logic [AW-1:0] cur_base, nxt_idx, rev_idx;
  logic [AW-1:0] addr_q;
  logic          valid_q;

  circ_agen_regs #(.AW(AW), .N(N)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(acc_en), .upd_sel(acc_ptr), .upd_val(nxt_idx),
    .rd_ptr(acc_ptr), .rd_mod(acc_mod),
    .cur_idx(cur_idx), .cur_anchor(cur_anchor), .cur_len(cur_len), .cur_modv(cur_modv)
  );

  circ_agen_update #(.AW(AW)) u_upd (
    .ptr(cur_idx), .anchor(cur_anchor), .len(cur_len), .modv(cur_modv),
    .base(cur_base), .nxt(nxt_idx)
  );

  circ_agen_bitrev #(.AW(AW)) u_rev (
    .din(cur_idx), .dout(rev_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= acc_en;
      if (acc_en) addr_q <= bitrev ? rev_idx : cur_idx;
    end
  end

  assign addr_out   = addr_q;
  assign addr_valid = valid_q;
endmodule

// File: rtl/circ_agen_chk.sv
module circ_agen_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_en,
  input logic          bitrev,
  input logic          addr_valid,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] cur_idx,
  input logic [AW-1:0] cur_len,
  input logic [AW-1:0] cur_modv,
  input logic [AW-1:0] cur_base,
  input logic [AW-1:0] nxt_idx
);
  function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  function automatic logic inwin(input logic [AW-1:0] v, input logic [AW-1:0] b,
                                 input logic [AW-1:0] l);
    return ({1'b0, v} >= {1'b0, b}) && ({1'b0, v} < ({1'b0, b} + {1'b0, l}));
  endfunction

  logic [AW-1:0] step_mag;
  assign step_mag = cur_modv[AW-1] ? (~cur_modv + AW'(1)) : cur_modv;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_valid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> !addr_valid);
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> $stable(addr_out));
  a_r2_issue_before_modify: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !bitrev) |=> (addr_out == $past(cur_idx)));
  a_r7_mirrored: assert property (@(posedge clk) disable iff (rst)
    (acc_en && bitrev) |=> (addr_out == mirror($past(cur_idx))));
  a_r5_stays_in_window: assert property (@(posedge clk) disable iff (rst)
    (acc_en && cur_len != '0 && inwin(cur_idx, cur_base, cur_len) && step_mag < cur_len)
      |-> inwin(nxt_idx, cur_base, cur_len));
endmodule

bind circ_agen circ_agen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .bitrev(bitrev),
  .addr_valid(addr_valid), .addr_out(addr_out),
  .cur_idx(cur_idx), .cur_len(cur_len), .cur_modv(cur_modv),
  .cur_base(cur_base), .nxt_idx(nxt_idx)
);

// File: tb/circ_agen_bench.sv
module circ_agen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [1:0]  wr_sel = '0;
  logic [13:0] wr_data = '0;
  logic        acc_en = 1'b0;
  logic [1:0]  acc_ptr = '0;
  logic [1:0]  acc_mod = '0;
  logic        bitrev = 1'b0;
  logic        addr_valid;
  logic [13:0] addr_out;

  int nchk = 0, nfail = 0;
  logic [13:0] exp_q[$];
  string       tag_q[$];
  int mdl_idx[4], mdl_anc[4], mdl_len[4], mdl_mod[4];

  always #4 clk = ~clk;

  circ_agen u_circ_agen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel),
    .wr_data(wr_data), .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod),
    .bitrev(bitrev), .addr_valid(addr_valid), .addr_out(addr_out)
  );

  function automatic logic [13:0] mrev(input int v);
    logic [13:0] r;
    for (int i = 0; i < 14; i++) r[i] = v[13-i];
    return r;
  endfunction

  function automatic int mnext(input int p, input int m);
    int mv, L, pw, base, n;
    mv = (mdl_mod[m] >= 8192) ? mdl_mod[m] - 16384 : mdl_mod[m];
    L = mdl_len[p];
    if (L == 0) return (mdl_idx[p] + mv + 16384) % 16384;
    pw = 1;
    while (pw < L) pw = pw * 2;
    base = mdl_anc[p] - (mdl_anc[p] % pw);
    n = mdl_idx[p] + mv;
    if (n > base + L - 1) n = n - L;
    else if (n < base) n = n + L;
    return n % 16384;
  endfunction

  task automatic cyc(input bit w, input int k, input int s, input int d,
                     input bit a, input int p, input int m, input bit br, input string tag);
    int nx;
    @(negedge clk);
    wr_en = w; wr_kind = k[1:0]; wr_sel = s[1:0]; wr_data = d[13:0];
    acc_en = a; acc_ptr = p[1:0]; acc_mod = m[1:0]; bitrev = br;
    if (a) begin
      exp_q.push_back(br ? mrev(mdl_idx[p]) : 14'(mdl_idx[p]));
      tag_q.push_back(tag);
      nx = mnext(p, m);
      mdl_idx[p] = nx;
    end
    if (w) begin
      case (k)
        0: begin mdl_idx[s] = d; mdl_anc[s] = d; end
        1: mdl_mod[s] = d;
        2: mdl_len[s] = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input int k, input int s, input int d);
    cyc(1, k, s, d, 0, 0, 0, 0, "");
  endtask
  task automatic acc(input int p, input int m, input bit br, input string tag);
    cyc(0, 0, 0, 0, 1, p, m, br, tag);
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  always @(negedge clk) begin
    if (!rst && addr_valid) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R2: unexpected valid, addr %0d expected none", addr_out);
      end else begin
        logic [13:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (addr_out !== e) begin
          nfail++;
          $display("FAIL %s: addr actual %0d expected %0d", t, addr_out, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    nfail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mdl_idx[i] = 0; mdl_anc[i] = 0; mdl_len[i] = 0; mdl_mod[i] = 0;
    end
    repeat (3) @(negedge clk);
    nchk++;
    if (addr_valid !== 1'b0 || addr_out !== 14'd0) begin
      nfail++;
      $display("FAIL R1: reset valid=%0b addr=%0d expected 0/0", addr_valid, addr_out);
    end
    rst = 1'b0;
    @(negedge clk);
    nchk++;
    if (addr_valid !== 1'b0 || addr_out !== 14'd0) begin
      nfail++;
      $display("FAIL R1: after reset valid=%0b addr=%0d expected 0/0", addr_valid, addr_out);
    end

    // R2/R3: linear stepping with different modify registers
    wr(1, 0, 1); wr(1, 1, 3); wr(1, 2, 16384 - 2); wr(1, 3, 100);
    wr(0, 0, 200);
    acc(0, 0, 0, "R2"); acc(0, 1, 0, "R3"); acc(0, 2, 0, "R3");
    acc(0, 3, 0, "R3"); acc(0, 0, 0, "R3");
    idle();

    // R4: linear wrap at 14 bits both ways
    wr(0, 1, 16383);
    acc(1, 0, 0, "R4"); acc(1, 0, 0, "R4"); acc(1, 2, 0, "R4"); acc(1, 0, 0, "R4");
    idle();

    // R5: circular forward, base 16 (block of 8), length 5, step 2
    wr(0, 2, 16); wr(2, 2, 5); wr(1, 1, 2);
    for (int i = 0; i < 7; i++) acc(2, 1, 0, "R5");
    idle();

    // R6: circular backward, anchor 70 in block of 16 at 64, length 10, step -3
    wr(0, 3, 70); wr(2, 3, 10); wr(1, 2, 16384 - 3);
    for (int i = 0; i < 6; i++) acc(3, 2, 0, "R6");
    idle();

    // R7: bit reversed issue, pointer keeps stepping
    wr(2, 0, 0); wr(1, 0, 1); wr(0, 0, 1);
    acc(0, 0, 1, "R7"); acc(0, 0, 1, "R7"); acc(0, 0, 0, "R7"); acc(0, 0, 1, "R7");
    idle();

    // R8: index write collides with access
    wr(0, 0, 100);
    cyc(1, 0, 0, 500, 1, 0, 0, 0, "R8");
    acc(0, 0, 0, "R8");
    idle();

    // R9: modify and length writes in the access cycle use old values
    wr(2, 1, 0); wr(1, 3, 4); wr(0, 1, 40);
    cyc(1, 1, 3, 10, 1, 1, 3, 0, "R9");
    acc(1, 3, 0, "R9"); acc(1, 3, 0, "R9");
    wr(0, 1, 32);
    cyc(1, 2, 1, 6, 1, 1, 3, 0, "R9");
    acc(1, 3, 0, "R9"); acc(1, 3, 0, "R9");
    idle();

    // R10: kind 3 write ignored; other pointers untouched
    cyc(1, 3, 2, 777, 0, 0, 0, 0, "");
    cyc(1, 3, 0, 9999, 0, 0, 0, 0, "");
    acc(2, 0, 0, "R10"); acc(3, 0, 0, "R10"); acc(0, 0, 0, "R10");
    idle();
    idle(); idle();

    nchk++;
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL R2: pending items actual %0d expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule